// File: doc/BRIEF.md
# Next-Hop Adjacency Table

This block holds a table of next-hop adjacency entries in on-chip RAM and serves two kinds of client. Software reaches it through a command port with a valid/ready handshake. Each command names an entry and asks for one of four operations: a read, a read that also clears the entry's activity flag, a plain write, or a write that only lands when the entry has not been active. Every accepted command returns exactly one response. The response carries a status code and, for a successful read, the whole entry.

The forwarding pipeline uses a separate lookup port. A lookup presents an index and gets the stored entry back one cycle later. If the entry is valid, the lookup also marks the entry as active. The hardware sets this activity flag and only a read-and-clear command clears it. Software can use the flag to update a next hop safely: it clears the flag, then issues a conditional write, which is dropped without complaint if traffic has used the entry in between.

When a valid entry is invalidated, it is put in quarantine for a fixed number of cycles. During that time every command that targets it completes with a try-again status. A small table of quarantine slots tracks these entries. An invalidation that finds no free slot is refused with try-again.

Top module: `nh_adj_table`

## Requirements
- R1: Command status codes are 0 (ok), 1 (try-again) and 2 (error). Opcode 0 reads an in-range entry with status ok, returning its valid flag, activity flag, egress interface, trap action, trap identifier and MAC. The response of any write or failed command carries all-zero entry fields.
- R2: Opcode 2 returns the entry like opcode 0, with the activity flag as it was before the command, and then clears that flag.
- R3: A write performed with the valid flag set stores the fields and sets the activity flag. A lookup that hits a valid entry also sets its activity flag.
- R4: Opcode 1 writes unconditionally. Opcode 3 writes only when the activity flag is clear. When the flag is set, opcode 3 leaves the entry untouched and still reports ok.
- R5: A write with the valid flag clear, issued to a valid entry, starts a quarantine of HOLD_CYC cycles. During the quarantine any command to that entry returns try-again and changes nothing. After the quarantine the entry can be read and written again.
- R6: The entry index is the concatenation {high 8 bits, low 16 bits}. Any index at or above DEPTH, and any opcode other than 0 to 3, returns error.
- R7: A read of an entry whose valid flag is 0 returns egress interface, trap action, trap identifier and MAC as zero.
- R8: A write with the valid flag set is rejected with error, leaving the entry unchanged, if any of these holds: the egress interface is at or above MAX_RIF; the trap action is above 4 (0 no-op, 1 trap, 2 mirror-to-CPU, 3 mirror, 4 discard-errors); the trap identifier is above 1.
- R9: At most one command is in flight. cmd_ready is high out of reset and low while a response waits. The response stays valid and stable until rsp_ready is high.
- R10: A lookup produces lk_rsp_valid exactly one cycle later. lk_hit is 1 only for an in-range valid entry, and the data returned is the entry's contents before any write in the same cycle, or zero on a miss.
- R11: When a command and a lookup reach the same entry in the same cycle, the command is judged on the activity value held before the lookup, and the lookup's activity set is applied after the command's update.
- R12: If all QSLOTS quarantine slots are busy, an invalidating write returns try-again and the entry stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 4 | Opcode |
| cmd_idx_lo | input | 16 | Entry index, low part |
| cmd_idx_hi | input | 8 | Entry index, high part |
| cmd_vld | input | 1 | Valid flag to write |
| cmd_rif | input | 16 | Egress interface to write |
| cmd_tact | input | 4 | Trap action to write |
| cmd_tid | input | 8 | Trap identifier to write |
| cmd_mac | input | 48 | Destination MAC to write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_status | output | 2 | Status code |
| rsp_vld | output | 1 | Entry valid flag read |
| rsp_act | output | 1 | Entry activity flag read |
| rsp_rif | output | 16 | Egress interface read |
| rsp_tact | output | 4 | Trap action read |
| rsp_tid | output | 8 | Trap identifier read |
| rsp_mac | output | 48 | Destination MAC read |
| lk_valid | input | 1 | Lookup request |
| lk_idx | input | 24 | Lookup index |
| lk_rsp_valid | output | 1 | Lookup result present |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_rif | output | 16 | Egress interface from lookup |
| lk_tact | output | 4 | Trap action from lookup |
| lk_tid | output | 8 | Trap identifier from lookup |
| lk_mac | output | 48 | Destination MAC from lookup |

## Verification
The bench targets four cases. The first is a conditional write landing on a cleared entry, and being dropped after the entry has been read back as active. A design that ignored the activity flag would overwrite the next hop. The second places a lookup in the same cycle as a conditional write or a read-and-clear. A design with the wrong ordering would drop the write, or would leave the activity flag clear after traffic had used the entry. The bench also invalidates entries: it checks for try-again while the quarantine lasts, for normal service once it expires, and for refusal once the slots run out. A design that leaked through quarantine would let a write land on an entry not yet free. The remaining checks cover the edge values MAX_RIF-1 and MAX_RIF, trap fields just past their limits, a high index part that sets DEPTH out of range, and a response held against rsp_ready low.

// File: rtl/nh_adj_pkg.sv
package nh_adj_pkg;
   localparam int RIF_W = 16;
   localparam int ACT_W = 4;
   localparam int TID_W = 8;
   localparam int MAC_W = 48;
   localparam int OP_W  = 4;
   localparam int IDX_W = 24;

   localparam logic [OP_W-1:0] OP_READ       = 4'd0;
   localparam logic [OP_W-1:0] OP_WRITE      = 4'd1;
   localparam logic [OP_W-1:0] OP_READ_CLR   = 4'd2;
   localparam logic [OP_W-1:0] OP_WRITE_IDLE = 4'd3;

   localparam logic [ACT_W-1:0] TACT_LAST = 4'd4;
   localparam logic [TID_W-1:0] TID_LAST  = 8'd1;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_RETRY = 2'd1,
      ST_ERR   = 2'd2
   } status_e;

   typedef struct packed {
      logic [RIF_W-1:0] rif;
      logic [ACT_W-1:0] tact;
      logic [TID_W-1:0] tid;
      logic [MAC_W-1:0] mac;
   } nh_data_t;
endpackage

// File: rtl/nh_adj_store.sv
// Entry payload RAM: one write port, two synchronous read ports.
// A read in the same cycle as a write to the same address returns old data.
module nh_adj_store
   import nh_adj_pkg::*;
#(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  nh_data_t      wr_data,
   input  logic          a_en,
   input  logic [AW-1:0] a_addr,
   output nh_data_t      a_data,
   input  logic          b_en,
   input  logic [AW-1:0] b_addr,
   output nh_data_t      b_data
);
   nh_data_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (a_en)  a_data <= mem[a_addr];
      if (b_en)  b_data <= mem[b_addr];
   end
endmodule

// File: rtl/nh_adj_flags.sv
// Per-entry valid and activity flags held in flops for same-cycle decisions.
// Update order within a cycle: command write, command clear, then lookup set.
module nh_adj_flags #(
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          c_upd,
   input  logic          c_clr,
   input  logic [AW-1:0] c_addr,
   input  logic          c_v_new,
   input  logic          l_set,
   input  logic [AW-1:0] l_addr,
   output logic          c_v,
   output logic          c_a,
   output logic          l_v
);
   logic [DEPTH-1:0] v_q;
   logic [DEPTH-1:0] a_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
         a_q <= '0;
      end else begin
         if (c_upd) begin
            v_q[c_addr] <= c_v_new;
            a_q[c_addr] <= c_v_new;
         end
         if (c_clr) a_q[c_addr] <= 1'b0;
         if (l_set) a_q[l_addr] <= 1'b1;
      end
   end

   assign c_v = v_q[c_addr];
   assign c_a = a_q[c_addr];
   assign l_v = v_q[l_addr];

   p_lookup_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      l_set |=> a_q[$past(l_addr)]);

   p_lookup_after_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (c_clr && l_set && (c_addr == l_addr)) |=> a_q[$past(c_addr)]);

   p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (c_clr && !(l_set && (l_addr == c_addr))) |=> !a_q[$past(c_addr)]);
endmodule

// File: rtl/nh_adj_quar.sv
// Quarantine slot table: each slot holds an index and a countdown.
module nh_adj_quar #(
   parameter int AW    = 8,
   parameter int SLOTS = 4,
   parameter int HOLD  = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] start_addr,
   input  logic [AW-1:0] q_addr,
   output logic          q_hit,
   output logic          full
);
   localparam int CW = $clog2(HOLD + 1);

   logic [SLOTS-1:0] busy;
   logic [SLOTS-1:0] hit_v;
   logic [SLOTS-1:0] take;
   logic             seen;

   always_comb begin
      take = '0;
      seen = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         if (!busy[i] && !seen) begin
            take[i] = 1'b1;
            seen    = 1'b1;
         end
      end
   end

   for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
      logic [AW-1:0] idx_q;
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
         end else if (start && take[gi]) begin
            idx_q <= start_addr;
            cnt_q <= CW'(HOLD);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end

      assign busy[gi]  = (cnt_q != '0);
      assign hit_v[gi] = busy[gi] && (idx_q == q_addr);

      p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CW'(HOLD));
   end

   assign q_hit = |hit_v;
   assign full  = &busy;

   p_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_v));

   p_room_r12: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !full);
endmodule

// File: rtl/nh_adj_table.sv
module nh_adj_table
   import nh_adj_pkg::*;
#(
   parameter int DEPTH    = 256,
   parameter int MAX_RIF  = 64,
   parameter int HOLD_CYC = 32,
   parameter int QSLOTS   = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   output logic        cmd_ready,
   input  logic [3:0]  cmd_op,
   input  logic [15:0] cmd_idx_lo,
   input  logic [7:0]  cmd_idx_hi,
   input  logic        cmd_vld,
   input  logic [15:0] cmd_rif,
   input  logic [3:0]  cmd_tact,
   input  logic [7:0]  cmd_tid,
   input  logic [47:0] cmd_mac,
   output logic        rsp_valid,
   input  logic        rsp_ready,
   output logic [1:0]  rsp_status,
   output logic        rsp_vld,
   output logic        rsp_act,
   output logic [15:0] rsp_rif,
   output logic [3:0]  rsp_tact,
   output logic [7:0]  rsp_tid,
   output logic [47:0] rsp_mac,
   input  logic        lk_valid,
   input  logic [23:0] lk_idx,
   output logic        lk_rsp_valid,
   output logic        lk_hit,
   output logic [15:0] lk_rif,
   output logic [3:0]  lk_tact,
   output logic [7:0]  lk_tid,
   output logic [47:0] lk_mac
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [IDX_W-1:0] DEPTH_LIM = IDX_W'(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH || DEPTH >= (1 << IDX_W)) begin : g_bad_depth
      $error("DEPTH must be a power of two between 2 and 2**23");
   end
   if (MAX_RIF < 1 || MAX_RIF > (1 << RIF_W)) begin : g_bad_rif
      $error("MAX_RIF must lie in 1 .. 2**16");
   end
   if (HOLD_CYC < 2 || QSLOTS < 1) begin : g_bad_quar
      $error("HOLD_CYC must be at least 2 and QSLOTS at least 1");
   end

   // command side decode
   logic [IDX_W-1:0] c_idx;
   logic [AW-1:0]    c_addr;
   logic             c_in_rng, accept, is_rd, is_wr, fld_bad;
   logic             cur_v, cur_a, q_hit, q_full;
   logic             wr_go, clr_go, q_go;
   status_e          st_n;
   nh_data_t         wr_data, a_data;

   assign c_idx    = {cmd_idx_hi, cmd_idx_lo};
   assign c_addr   = c_idx[AW-1:0];
   assign c_in_rng = (c_idx < DEPTH_LIM);
   assign accept   = cmd_valid && cmd_ready;
   assign is_rd    = (cmd_op == OP_READ) || (cmd_op == OP_READ_CLR);
   assign is_wr    = (cmd_op == OP_WRITE) || (cmd_op == OP_WRITE_IDLE);
   assign fld_bad  = cmd_vld && ((32'(cmd_rif) >= 32'(MAX_RIF)) ||
                                 (cmd_tact > TACT_LAST) || (cmd_tid > TID_LAST));
   assign wr_data  = cmd_vld ? {cmd_rif, cmd_tact, cmd_tid, cmd_mac} : '0;

   always_comb begin
      st_n   = ST_OK;
      wr_go  = 1'b0;
      clr_go = 1'b0;
      q_go   = 1'b0;
      if (!(is_rd || is_wr) || !c_in_rng) begin
         st_n = ST_ERR;
      end else if (q_hit) begin
         st_n = ST_RETRY;
      end else if (is_rd) begin
         clr_go = (cmd_op == OP_READ_CLR);
      end else if (fld_bad) begin
         st_n = ST_ERR;
      end else if ((cmd_op == OP_WRITE_IDLE) && cur_a) begin
         st_n = ST_OK;
      end else if (!cmd_vld && cur_v && q_full) begin
         st_n = ST_RETRY;
      end else begin
         wr_go = 1'b1;
         q_go  = !cmd_vld && cur_v;
      end
   end

   // lookup side decode
   logic [AW-1:0] l_addr;
   logic          l_in_rng, l_v, l_set;
   nh_data_t      b_data;

   assign l_addr   = lk_idx[AW-1:0];
   assign l_in_rng = (lk_idx < DEPTH_LIM);
   assign l_set    = lk_valid && l_in_rng && l_v;

   nh_adj_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk     (clk),
      .wr_en   (accept && wr_go),
      .wr_addr (c_addr),
      .wr_data (wr_data),
      .a_en    (accept),
      .a_addr  (c_addr),
      .a_data  (a_data),
      .b_en    (lk_valid),
      .b_addr  (l_addr),
      .b_data  (b_data)
   );

   nh_adj_flags #(.DEPTH(DEPTH), .AW(AW)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .c_upd   (accept && wr_go),
      .c_clr   (accept && clr_go),
      .c_addr  (c_addr),
      .c_v_new (cmd_vld),
      .l_set   (l_set),
      .l_addr  (l_addr),
      .c_v     (cur_v),
      .c_a     (cur_a),
      .l_v     (l_v)
   );

   nh_adj_quar #(.AW(AW), .SLOTS(QSLOTS), .HOLD(HOLD_CYC)) u_quar (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept && q_go),
      .start_addr (c_addr),
      .q_addr     (c_addr),
      .q_hit      (q_hit),
      .full       (q_full)
   );

   // response registers
   logic    busy_q, rd_q, v_snap, a_snap;
   status_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         rd_q   <= 1'b0;
         v_snap <= 1'b0;
         a_snap <= 1'b0;
         st_q   <= ST_OK;
      end else if (accept) begin
         busy_q <= 1'b1;
         rd_q   <= is_rd && (st_n == ST_OK);
         v_snap <= cur_v;
         a_snap <= cur_a;
         st_q   <= st_n;
      end else if (busy_q && rsp_ready) begin
         busy_q <= 1'b0;
      end
   end

   nh_data_t rsp_data;
   assign rsp_data   = (rd_q && v_snap) ? a_data : '0;
   assign cmd_ready  = !busy_q;
   assign rsp_valid  = busy_q;
   assign rsp_status = st_q;
   assign rsp_vld    = rd_q && v_snap;
   assign rsp_act    = rd_q && a_snap;
   assign rsp_rif    = rsp_data.rif;
   assign rsp_tact   = rsp_data.tact;
   assign rsp_tid    = rsp_data.tid;
   assign rsp_mac    = rsp_data.mac;

   // lookup response
   logic lk_v_q, lk_hit_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_v_q   <= 1'b0;
         lk_hit_q <= 1'b0;
      end else begin
         lk_v_q   <= lk_valid;
         lk_hit_q <= l_set;
      end
   end

   nh_data_t lk_data;
   assign lk_data      = lk_hit_q ? b_data : '0;
   assign lk_rsp_valid = lk_v_q;
   assign lk_hit       = lk_hit_q;
   assign lk_rif       = lk_data.rif;
   assign lk_tact      = lk_data.tact;
   assign lk_tid       = lk_data.tid;
   assign lk_mac       = lk_data.mac;

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !cmd_ready);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) &&
                                     $stable(rsp_mac) && $stable(rsp_rif)));

   p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_vld) |-> (rsp_rif == '0 && rsp_tact == '0 &&
                                   rsp_tid == '0 && rsp_mac == '0));

   p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !c_in_rng) |=> (rsp_status == ST_ERR));

   p_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && c_in_rng && (is_rd || is_wr) && q_hit) |=> (rsp_status == ST_RETRY));

   p_lk_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> lk_rsp_valid);

   p_lk_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !lk_rsp_valid);
endmodule

// File: tb/nh_adj_table_bench.sv
module nh_adj_table_bench;
   import nh_adj_pkg::*;

   localparam int DEPTH = 16;
   localparam int MAXR  = 10;
   localparam int HOLD  = 40;
   localparam int QS    = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_ready;
   logic [3:0]  cmd_op = '0;
   logic [15:0] cmd_idx_lo = '0;
   logic [7:0]  cmd_idx_hi = '0;
   logic        cmd_vld = 1'b0;
   logic [15:0] cmd_rif = '0;
   logic [3:0]  cmd_tact = '0;
   logic [7:0]  cmd_tid = '0;
   logic [47:0] cmd_mac = '0;
   logic        rsp_valid, rsp_ready = 1'b1;
   logic [1:0]  rsp_status;
   logic        rsp_vld, rsp_act;
   logic [15:0] rsp_rif;
   logic [3:0]  rsp_tact;
   logic [7:0]  rsp_tid;
   logic [47:0] rsp_mac;
   logic        lk_valid = 1'b0;
   logic [23:0] lk_idx = '0;
   logic        lk_rsp_valid, lk_hit;
   logic [15:0] lk_rif;
   logic [3:0]  lk_tact;
   logic [7:0]  lk_tid;
   logic [47:0] lk_mac;

   always #2 clk = ~clk;

   nh_adj_table #(.DEPTH(DEPTH), .MAX_RIF(MAXR), .HOLD_CYC(HOLD), .QSLOTS(QS)) u_nh_adj_table (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_idx_lo(cmd_idx_lo), .cmd_idx_hi(cmd_idx_hi), .cmd_vld(cmd_vld),
      .cmd_rif(cmd_rif), .cmd_tact(cmd_tact), .cmd_tid(cmd_tid), .cmd_mac(cmd_mac),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status),
      .rsp_vld(rsp_vld), .rsp_act(rsp_act), .rsp_rif(rsp_rif), .rsp_tact(rsp_tact),
      .rsp_tid(rsp_tid), .rsp_mac(rsp_mac),
      .lk_valid(lk_valid), .lk_idx(lk_idx), .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit),
      .lk_rif(lk_rif), .lk_tact(lk_tact), .lk_tid(lk_tid), .lk_mac(lk_mac)
   );

   typedef struct packed {
      logic [1:0]  st;
      logic        v;
      logic        a;
      logic [15:0] rif;
      logic [3:0]  tact;
      logic [7:0]  tid;
      logic [47:0] mac;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    total = 0;
   int    bad = 0;
   bit    done = 1'b0;

   localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
   localparam logic [47:0] MAC_B = 48'h02_aa_bb_cc_dd_ee;
   localparam logic [47:0] MAC_C = 48'h06_01_02_03_04_05;
   localparam logic [47:0] MAC_D = 48'h0a_99_88_77_66_55;
   localparam logic [47:0] MAC_E = 48'h0e_10_20_30_40_50;

   function automatic exp_t ex(logic [1:0] st, logic v, logic a, logic [15:0] rif,
                               logic [3:0] tact, logic [7:0] tid, logic [47:0] mac);
      return {st, v, a, rif, tact, tid, mac};
   endfunction

   task automatic check(bit ok, string msg);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s", msg);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_ready) begin
         exp_t  got;
         exp_t  e;
         string t;
         got = {rsp_status, rsp_vld, rsp_act, rsp_rif, rsp_tact, rsp_tid, rsp_mac};
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R9 unexpected response actual=%h expected=none", got);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (got !== e) begin
               bad++;
               $display("FAIL %s response actual=%h expected=%h", t, got, e);
            end
         end
      end
   end

   task automatic send(input logic [3:0] op, input logic [23:0] idx, input logic v,
                       input logic [15:0] rif, input logic [3:0] tact, input logic [7:0] tid,
                       input logic [47:0] mac, input exp_t e, input string tag);
      while (!cmd_ready) @(negedge clk);
      cmd_valid  = 1'b1;
      cmd_op     = op;
      cmd_idx_lo = idx[15:0];
      cmd_idx_hi = idx[23:16];
      cmd_vld    = v;
      cmd_rif    = rif;
      cmd_tact   = tact;
      cmd_tid    = tid;
      cmd_mac    = mac;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic rd(input logic [3:0] op, input logic [23:0] idx, input exp_t e, input string tag);
      send(op, idx, 1'b0, '0, '0, '0, '0, e, tag);
   endtask

   task automatic wr(input logic [3:0] op, input logic [23:0] idx, input logic v,
                     input logic [15:0] rif, input logic [3:0] tact, input logic [7:0] tid,
                     input logic [47:0] mac, input logic [1:0] st, input string tag);
      send(op, idx, v, rif, tact, tid, mac, ex(st, 0, 0, '0, '0, '0, '0), tag);
   endtask

   task automatic lk(input logic [23:0] idx, input logic hit, input logic [15:0] rif,
                     input logic [3:0] tact, input logic [7:0] tid, input logic [47:0] mac,
                     input string tag);
      lk_valid = 1'b1;
      lk_idx   = idx;
      @(negedge clk);
      lk_valid = 1'b0;
      check(lk_rsp_valid === 1'b1 && lk_hit === hit && lk_rif === rif &&
            lk_tact === tact && lk_tid === tid && lk_mac === mac,
            $sformatf("%s lookup actual=%b/%b/%h/%h/%h/%h expected=1/%b/%h/%h/%h/%h", tag,
                      lk_rsp_valid, lk_hit, lk_rif, lk_tact, lk_tid, lk_mac,
                      hit, rif, tact, tid, mac));
   endtask

   task automatic wait_idle();
      while (!cmd_ready || rsp_valid || exp_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(cmd_ready === 1'b1 && rsp_valid === 1'b0 && lk_rsp_valid === 1'b0,
            $sformatf("R9 reset actual=%b%b%b expected=100", cmd_ready, rsp_valid, lk_rsp_valid));
      rst_n = 1'b1;
      @(negedge clk);

      // R7 read of empty entry, R1/R3 write and readback
      rd(OP_READ, 24'd3, ex(ST_OK, 0, 0, '0, '0, '0, '0), "R7");
      wr(OP_WRITE, 24'd3, 1, 16'd5, 4'd2, 8'd1, MAC_A, ST_OK, "R3");
      rd(OP_READ, 24'd3, ex(ST_OK, 1, 1, 16'd5, 4'd2, 8'd1, MAC_A), "R1");
      // R2 read-and-clear
      rd(OP_READ_CLR, 24'd3, ex(ST_OK, 1, 1, 16'd5, 4'd2, 8'd1, MAC_A), "R2");
      rd(OP_READ, 24'd3, ex(ST_OK, 1, 0, 16'd5, 4'd2, 8'd1, MAC_A), "R2");
      // R10 lookup hit, R3 activity from lookup
      wait_idle();
      lk(24'd3, 1, 16'd5, 4'd2, 8'd1, MAC_A, "R10");
      rd(OP_READ, 24'd3, ex(ST_OK, 1, 1, 16'd5, 4'd2, 8'd1, MAC_A), "R3");
      // R4 conditional write performed then dropped
      rd(OP_READ_CLR, 24'd3, ex(ST_OK, 1, 1, 16'd5, 4'd2, 8'd1, MAC_A), "R4");
      wr(OP_WRITE_IDLE, 24'd3, 1, 16'd7, 4'd2, 8'd1, MAC_B, ST_OK, "R4");
      rd(OP_READ, 24'd3, ex(ST_OK, 1, 1, 16'd7, 4'd2, 8'd1, MAC_B), "R4");
      wr(OP_WRITE_IDLE, 24'd3, 1, 16'd9, 4'd0, 8'd0, MAC_C, ST_OK, "R4");
      rd(OP_READ, 24'd3, ex(ST_OK, 1, 1, 16'd7, 4'd2, 8'd1, MAC_B), "R4");

      // R8 field limits
      wr(OP_WRITE, 24'd5, 1, 16'd10, 4'd0, 8'd0, MAC_C, ST_ERR, "R8");
      rd(OP_READ, 24'd5, ex(ST_OK, 0, 0, '0, '0, '0, '0), "R8");
      wr(OP_WRITE, 24'd5, 1, 16'd9, 4'd4, 8'd1, MAC_C, ST_OK, "R8");
      wr(OP_WRITE, 24'd5, 1, 16'd1, 4'd5, 8'd0, MAC_D, ST_ERR, "R8");
      wr(OP_WRITE, 24'd5, 1, 16'd1, 4'd0, 8'd2, MAC_D, ST_ERR, "R8");
      rd(OP_READ, 24'd5, ex(ST_OK, 1, 1, 16'd9, 4'd4, 8'd1, MAC_C), "R8");
      // R6 opcode and range
      rd(4'd7, 24'd5, ex(ST_ERR, 0, 0, '0, '0, '0, '0), "R6");
      rd(OP_READ, 24'd16, ex(ST_ERR, 0, 0, '0, '0, '0, '0), "R6");
      rd(OP_READ, 24'h01_0003, ex(ST_ERR, 0, 0, '0, '0, '0, '0), "R6");
      // R10 misses
      wait_idle();
      lk(24'd20, 0, '0, '0, '0, '0, "R10");
      lk(24'd4, 0, '0, '0, '0, '0, "R10");
      lk(24'd5, 1, 16'd9, 4'd4, 8'd1, MAC_C, "R10");

      // R11 same-cycle command and lookup
      rd(OP_READ_CLR, 24'd3, ex(ST_OK, 1, 1, 16'd7, 4'd2, 8'd1, MAC_B), "R11");
      wait_idle();
      fork
         wr(OP_WRITE_IDLE, 24'd3, 1, 16'd4, 4'd1, 8'd0, MAC_C, ST_OK, "R11");
         lk(24'd3, 1, 16'd7, 4'd2, 8'd1, MAC_B, "R11");
      join
      rd(OP_READ, 24'd3, ex(ST_OK, 1, 1, 16'd4, 4'd1, 8'd0, MAC_C), "R11");
      wait_idle();
      fork
         rd(OP_READ_CLR, 24'd3, ex(ST_OK, 1, 1, 16'd4, 4'd1, 8'd0, MAC_C), "R11");
         lk(24'd3, 1, 16'd4, 4'd1, 8'd0, MAC_C, "R11");
      join
      rd(OP_READ, 24'd3, ex(ST_OK, 1, 1, 16'd4, 4'd1, 8'd0, MAC_C), "R11");

      // R5 quarantine
      wr(OP_WRITE, 24'd3, 0, '0, '0, '0, '0, ST_OK, "R5");
      rd(OP_READ, 24'd3, ex(ST_RETRY, 0, 0, '0, '0, '0, '0), "R5");
      wr(OP_WRITE, 24'd3, 1, 16'd1, 4'd0, 8'd0, MAC_D, ST_RETRY, "R5");
      wait_idle();
      lk(24'd3, 0, '0, '0, '0, '0, "R5");
      repeat (HOLD + 10) @(negedge clk);
      rd(OP_READ, 24'd3, ex(ST_OK, 0, 0, '0, '0, '0, '0), "R5");
      wr(OP_WRITE, 24'd3, 1, 16'd1, 4'd0, 8'd0, MAC_D, ST_OK, "R5");
      rd(OP_READ, 24'd3, ex(ST_OK, 1, 1, 16'd1, 4'd0, 8'd0, MAC_D), "R5");

      // R12 slots exhausted
      wr(OP_WRITE, 24'd6, 1, 16'd2, 4'd0, 8'd0, MAC_E, ST_OK, "R12");
      wr(OP_WRITE, 24'd7, 1, 16'd2, 4'd0, 8'd0, MAC_E, ST_OK, "R12");
      wr(OP_WRITE, 24'd8, 1, 16'd2, 4'd0, 8'd0, MAC_E, ST_OK, "R12");
      wr(OP_WRITE, 24'd6, 0, '0, '0, '0, '0, ST_OK, "R12");
      wr(OP_WRITE, 24'd7, 0, '0, '0, '0, '0, ST_OK, "R12");
      wr(OP_WRITE, 24'd8, 0, '0, '0, '0, '0, ST_RETRY, "R12");
      rd(OP_READ, 24'd8, ex(ST_OK, 1, 1, 16'd2, 4'd0, 8'd0, MAC_E), "R12");

      // R9 response held under back-pressure
      wait_idle();
      rsp_ready = 1'b0;
      rd(OP_READ, 24'd8, ex(ST_OK, 1, 1, 16'd2, 4'd0, 8'd0, MAC_E), "R9");
      repeat (3) @(negedge clk);
      check(rsp_valid === 1'b1 && cmd_ready === 1'b0 && rsp_mac === MAC_E,
            $sformatf("R9 hold actual=%b%b/%h expected=10/%h", rsp_valid, cmd_ready, rsp_mac, MAC_E));
      rsp_ready = 1'b1;
      wait_idle();
      check(cmd_ready === 1'b1 && rsp_valid === 1'b0,
            $sformatf("R9 release actual=%b%b expected=10", cmd_ready, rsp_valid));

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule